// File: doc/BRIEF.md
# Base Integer Instruction Decoder

This block turns one 32-bit instruction word of the base integer instruction set into everything the execute stage needs. It works out the instruction class from the 7-bit major opcode, checks the minor fields for that class, and produces datapath controls, the three register indices, an ALU operation code and a sign-extended 32-bit immediate. It also raises a flag for the environment-call, breakpoint and memory-fence words, and an illegal flag for any word it does not recognise.

The block is purely combinational and has no clock or reset. A pipeline places it between the fetch register and the decode/execute register. A recognised word drives the controls directly. An unrecognised word yields all enables low, an all-zero immediate and the add code, with only `illegal_o` set, so an exception path can take over. Compressed words, control/status register access and extensions all decode as illegal.

Top module: `int_inst_decoder`

## Requirements
- R1: Each major opcode is decoded to its routing controls. Register-immediate ALU `0010011` and load-upper `0110111` select register/immediate operands with ALU write-back. Add-upper-to-pc `0010111` and direct jump `1101111` select pc and immediate operands. Register-register `0110011` selects two registers. Write-back code `wb_sel_o` is 0 for ALU, 1 for memory and 2 for the link address (pc+4).
- R2: `rd_o`, `rs1_o` and `rs2_o` always equal inst[11:7], inst[19:15] and inst[24:20].
- R3: The immediate depends on the class. It is inst[31:20] for register-immediate, load and indirect jump. It is {inst[31:25],inst[11:7]} for stores, {inst[31],inst[7],inst[30:25],inst[11:8],0} for branches (opcode `1100011`), {inst[31:12],12'b0} for the upper-immediate forms and {inst[31],inst[19:12],inst[20],inst[30:21],0} for the direct jump. Every one is sign-extended from its top bit. The immediate is 0 for register-register, fence, system and illegal words.
- R4: The shift-immediate forms have funct3 001 (left) and 101 (right). They are legal only when inst[31:25] is 0000000 (logical) or, for funct3 101, 0100000 (arithmetic). Their immediate is the 5-bit shift amount inst[24:20], zero-extended.
- R5: A register-register word is legal when funct7 is 0000000 with any funct3, or when funct7 is 0100000 with funct3 000 (subtract) or 101 (arithmetic right shift). Every other combination is illegal.
- R6: `alu_op_o` uses the codes add 0, sub 1, shift-left 2, signed-less-than 3, unsigned-less-than 4, xor 5, logical-right 6, arithmetic-right 7, or 8, and 9, pass-B 10. For both ALU classes the code follows funct3 (000 add/sub, 001 sll, 010 slt, 011 sltu, 100 xor, 101 srl/sra, 110 or, 111 and). Load-upper uses pass-B. Loads, stores and jumps use add.
- R7: Loads (opcode `0000011`) accept funct3 000, 001, 010, 100 and 101. Stores (opcode `0100011`) accept 000, 001 and 010. `mem_size_o` is funct3[1:0] (0 byte, 1 half, 2 word). `mem_unsigned_o` is funct3[2] for loads and 0 for stores. A load writes back from memory.
- R8: Branches set `branch_o` and compare two registers. funct3 00x uses sub, 10x uses slt and 11x uses sltu. `br_inv_o` equals funct3[0]. funct3 010 and 011 are illegal.
- R9: The direct jump (opcode `1101111`) and the indirect jump (opcode `1100111`, funct3 000 only) set `jump_o`, add their operands and write back the link address. The indirect jump takes rs1 rather than pc as operand A.
- R10: A system word (opcode `1110011`) with every bit from 31 down to 7 at zero raises `env_call_o`. The same word with inst[31:20]=1 raises `brk_o`. Every other system word is illegal.
- R11: A fence word (opcode `0001111`, funct3 000) raises `fence_o` and no other control.
- R12: An illegal word drives every enable and control low, with code 0 and immediate 0. Stores, branches, fences and system words never assert `reg_we_o`.
- R13: At most one of `env_call_o`, `brk_o`, `fence_o` and `illegal_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_i | input | 32 | Instruction word |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| imm_o | output | 32 | Sign-extended immediate |
| alu_op_o | output | 4 | ALU operation code |
| src_a_pc_o | output | 1 | ALU operand A is the pc |
| src_b_imm_o | output | 1 | ALU operand B is the immediate |
| reg_we_o | output | 1 | Register write enable |
| wb_sel_o | output | 2 | Write-back source select |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| mem_size_o | output | 2 | Access size |
| mem_unsigned_o | output | 1 | Zero-extend loaded data |
| branch_o | output | 1 | Conditional branch |
| br_inv_o | output | 1 | Invert the compare result |
| jump_o | output | 1 | Unconditional jump |
| env_call_o | output | 1 | Environment call |
| brk_o | output | 1 | Breakpoint |
| fence_o | output | 1 | Memory fence |
| illegal_o | output | 1 | Unrecognised encoding |

## Verification
The hardest cases are words that are one field away from legal. Examples are a shift-immediate whose upper bits are 0000001, a subtract-style funct7 paired with the wrong funct3, and a system word with a single stray bit in the rd or rs1 field. Random words almost never land on these. The stimulus therefore crosses every major opcode with every funct3 and a set of five funct7 patterns (zero, the alternate 0100000, and three near misses), with varying register fields. Directed words then cover the exact call and breakpoint encodings, their single-bit neighbours, and the sign extremes of each immediate layout.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int XLEN     = 32;
    localparam int RIDX_W   = 5;
    localparam int SHAMT_W  = $clog2(XLEN);

    typedef enum logic [6:0] {
        OPC_LOAD   = 7'b0000011,
        OPC_FENCE  = 7'b0001111,
        OPC_OPIMM  = 7'b0010011,
        OPC_AUIPC  = 7'b0010111,
        OPC_STORE  = 7'b0100011,
        OPC_OP     = 7'b0110011,
        OPC_LUI    = 7'b0110111,
        OPC_BRANCH = 7'b1100011,
        OPC_JALR   = 7'b1100111,
        OPC_JAL    = 7'b1101111,
        OPC_SYSTEM = 7'b1110011
    } opc_e;

    typedef enum logic [3:0] {
        ALU_ADD   = 4'd0,
        ALU_SUB   = 4'd1,
        ALU_SLL   = 4'd2,
        ALU_SLT   = 4'd3,
        ALU_SLTU  = 4'd4,
        ALU_XOR   = 4'd5,
        ALU_SRL   = 4'd6,
        ALU_SRA   = 4'd7,
        ALU_OR    = 4'd8,
        ALU_AND   = 4'd9,
        ALU_PASSB = 4'd10
    } alu_op_e;

    typedef enum logic [2:0] {
        IMM_NONE,
        IMM_I,
        IMM_SH,
        IMM_S,
        IMM_B,
        IMM_U,
        IMM_J
    } imm_kind_e;

    typedef enum logic [1:0] {
        WB_ALU  = 2'd0,
        WB_MEM  = 2'd1,
        WB_LINK = 2'd2
    } wb_sel_e;

    typedef struct packed {
        logic       src_a_pc;
        logic       src_b_imm;
        logic       reg_we;
        wb_sel_e    wb_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic [1:0] mem_size;
        logic       mem_uns;
        logic       branch;
        logic       br_inv;
        logic       jump;
        logic       env_call;
        logic       brk;
        logic       fence;
    } ctrl_t;

endpackage

// File: rtl/idec_class.sv
// Opcode classification, minor-field legality and control generation.
module idec_class
    import idec_pkg::*;
(
    input  logic [XLEN-1:0] inst,
    output logic            legal,
    output ctrl_t           ctrl,
    output imm_kind_e       kind
);

    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic       sys_tail_zero;

    assign opc = inst[6:0];
    assign f3  = inst[14:12];
    assign f7  = inst[31:25];
    // rd, funct3 and rs1 all zero: common to both system forms
    assign sys_tail_zero = (inst[19:7] == '0);

    always_comb begin
        legal = 1'b0;
        ctrl  = '0;
        kind  = IMM_NONE;
        unique case (opc)
            OPC_OPIMM: begin
                unique case (f3)
                    3'b001:  legal = (f7 == 7'b0000000);
                    3'b101:  legal = (f7 == 7'b0000000) || (f7 == 7'b0100000);
                    default: legal = 1'b1;
                endcase
                ctrl.src_b_imm = 1'b1;
                ctrl.reg_we    = 1'b1;
                ctrl.wb_sel    = WB_ALU;
                kind           = (f3[1:0] == 2'b01) ? IMM_SH : IMM_I;
            end
            OPC_OP: begin
                legal = (f7 == 7'b0000000) ||
                        ((f7 == 7'b0100000) && ((f3 == 3'b000) || (f3 == 3'b101)));
                ctrl.reg_we = 1'b1;
                ctrl.wb_sel = WB_ALU;
            end
            OPC_LUI: begin
                legal          = 1'b1;
                ctrl.src_b_imm = 1'b1;
                ctrl.reg_we    = 1'b1;
                kind           = IMM_U;
            end
            OPC_AUIPC: begin
                legal          = 1'b1;
                ctrl.src_a_pc  = 1'b1;
                ctrl.src_b_imm = 1'b1;
                ctrl.reg_we    = 1'b1;
                kind           = IMM_U;
            end
            OPC_JAL: begin
                legal          = 1'b1;
                ctrl.src_a_pc  = 1'b1;
                ctrl.src_b_imm = 1'b1;
                ctrl.reg_we    = 1'b1;
                ctrl.jump      = 1'b1;
                ctrl.wb_sel    = WB_LINK;
                kind           = IMM_J;
            end
            OPC_JALR: begin
                legal          = (f3 == 3'b000);
                ctrl.src_b_imm = 1'b1;
                ctrl.reg_we    = 1'b1;
                ctrl.jump      = 1'b1;
                ctrl.wb_sel    = WB_LINK;
                kind           = IMM_I;
            end
            OPC_BRANCH: begin
                legal       = (f3[2:1] != 2'b01);
                ctrl.branch = 1'b1;
                ctrl.br_inv = f3[0];
                kind        = IMM_B;
            end
            OPC_LOAD: begin
                legal          = (f3[1:0] != 2'b11) && !(f3[2] && f3[1]);
                ctrl.src_b_imm = 1'b1;
                ctrl.reg_we    = 1'b1;
                ctrl.mem_rd    = 1'b1;
                ctrl.wb_sel    = WB_MEM;
                ctrl.mem_size  = f3[1:0];
                ctrl.mem_uns   = f3[2];
                kind           = IMM_I;
            end
            OPC_STORE: begin
                legal          = !f3[2] && (f3[1:0] != 2'b11);
                ctrl.src_b_imm = 1'b1;
                ctrl.mem_wr    = 1'b1;
                ctrl.mem_size  = f3[1:0];
                kind           = IMM_S;
            end
            OPC_FENCE: begin
                legal      = (f3 == 3'b000);
                ctrl.fence = 1'b1;
            end
            OPC_SYSTEM: begin
                ctrl.env_call = sys_tail_zero && (inst[31:20] == 12'd0);
                ctrl.brk      = sys_tail_zero && (inst[31:20] == 12'd1);
                legal         = ctrl.env_call || ctrl.brk;
            end
            default: legal = 1'b0;
        endcase
        if (!legal) begin
            ctrl = '0;
            kind = IMM_NONE;
        end
    end

endmodule

// File: rtl/idec_alusel.sv
// ALU operation selection from opcode and minor fields.
module idec_alusel
    import idec_pkg::*;
(
    input  logic [6:0] opc,
    input  logic [2:0] f3,
    input  logic       alt,      // inst[30]
    output alu_op_e    alu_op
);

    alu_op_e arith_op;

    // shared by both ALU classes; subtract only for the register form
    always_comb begin
        unique case (f3)
            3'b000:  arith_op = (alt && (opc == OPC_OP)) ? ALU_SUB : ALU_ADD;
            3'b001:  arith_op = ALU_SLL;
            3'b010:  arith_op = ALU_SLT;
            3'b011:  arith_op = ALU_SLTU;
            3'b100:  arith_op = ALU_XOR;
            3'b101:  arith_op = alt ? ALU_SRA : ALU_SRL;
            3'b110:  arith_op = ALU_OR;
            default: arith_op = ALU_AND;
        endcase
    end

    always_comb begin
        unique case (opc)
            OPC_OPIMM,
            OPC_OP:     alu_op = arith_op;
            OPC_LUI:    alu_op = ALU_PASSB;
            OPC_BRANCH: begin
                unique case (f3[2:1])
                    2'b00:   alu_op = ALU_SUB;
                    2'b10:   alu_op = ALU_SLT;
                    2'b11:   alu_op = ALU_SLTU;
                    default: alu_op = ALU_ADD;
                endcase
            end
            default:    alu_op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/idec_immgen.sv
// Immediate assembly for every layout, sign-extended to XLEN.
module idec_immgen
    import idec_pkg::*;
(
    input  logic [31:7]     fld,
    input  imm_kind_e       kind,
    output logic [XLEN-1:0] imm
);

    localparam int EXT_I = XLEN - 12;
    localparam int EXT_B = XLEN - 13;
    localparam int EXT_J = XLEN - 21;
    localparam int EXT_U = XLEN - 32;

    logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j, imm_sh;
    logic            sgn;

    assign sgn    = fld[31];
    assign imm_i  = {{EXT_I{sgn}}, fld[31:20]};
    assign imm_s  = {{EXT_I{sgn}}, fld[31:25], fld[11:7]};
    assign imm_b  = {{EXT_B{sgn}}, fld[31], fld[7], fld[30:25], fld[11:8], 1'b0};
    assign imm_j  = {{EXT_J{sgn}}, fld[31], fld[19:12], fld[20], fld[30:21], 1'b0};
    assign imm_sh = {{(XLEN-SHAMT_W){1'b0}}, fld[20 +: SHAMT_W]};

    generate
        if (EXT_U > 0) begin : g_u_wide
            assign imm_u = {{EXT_U{sgn}}, fld[31:12], 12'b0};
        end else begin : g_u_exact
            assign imm_u = {fld[31:12], 12'b0};
        end
    endgenerate

    always_comb begin
        unique case (kind)
            IMM_I:   imm = imm_i;
            IMM_SH:  imm = imm_sh;
            IMM_S:   imm = imm_s;
            IMM_B:   imm = imm_b;
            IMM_U:   imm = imm_u;
            IMM_J:   imm = imm_j;
            default: imm = '0;
        endcase
    end

endmodule

// File: rtl/int_inst_decoder.sv
module int_inst_decoder
    import idec_pkg::*;
(
    input  logic [31:0] inst_i,
    output logic [4:0]  rd_o,
    output logic [4:0]  rs1_o,
    output logic [4:0]  rs2_o,
    output logic [31:0] imm_o,
    output logic [3:0]  alu_op_o,
    output logic        src_a_pc_o,
    output logic        src_b_imm_o,
    output logic        reg_we_o,
    output logic [1:0]  wb_sel_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic [1:0]  mem_size_o,
    output logic        mem_unsigned_o,
    output logic        branch_o,
    output logic        br_inv_o,
    output logic        jump_o,
    output logic        env_call_o,
    output logic        brk_o,
    output logic        fence_o,
    output logic        illegal_o
);

    logic      legal;
    ctrl_t     ctrl;
    imm_kind_e kind;
    alu_op_e   alu_raw;

    idec_class u_class (
        .inst  (inst_i),
        .legal (legal),
        .ctrl  (ctrl),
        .kind  (kind)
    );

    idec_alusel u_alusel (
        .opc    (inst_i[6:0]),
        .f3     (inst_i[14:12]),
        .alt    (inst_i[30]),
        .alu_op (alu_raw)
    );

    idec_immgen u_immgen (
        .fld  (inst_i[31:7]),
        .kind (kind),
        .imm  (imm_o)
    );

    assign rd_o  = inst_i[11:7];
    assign rs1_o = inst_i[19:15];
    assign rs2_o = inst_i[24:20];

    assign alu_op_o       = legal ? alu_raw : ALU_ADD;
    assign src_a_pc_o     = ctrl.src_a_pc;
    assign src_b_imm_o    = ctrl.src_b_imm;
    assign reg_we_o       = ctrl.reg_we;
    assign wb_sel_o       = ctrl.wb_sel;
    assign mem_rd_o       = ctrl.mem_rd;
    assign mem_wr_o       = ctrl.mem_wr;
    assign mem_size_o     = ctrl.mem_size;
    assign mem_unsigned_o = ctrl.mem_uns;
    assign branch_o       = ctrl.branch;
    assign br_inv_o       = ctrl.br_inv;
    assign jump_o         = ctrl.jump;
    assign env_call_o     = ctrl.env_call;
    assign brk_o          = ctrl.brk;
    assign fence_o        = ctrl.fence;
    assign illegal_o      = !legal;

endmodule

// File: rtl/int_inst_decoder_chk.sv
module int_inst_decoder_chk (
    input logic       reg_we,
    input logic [1:0] wb_sel,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       branch,
    input logic       jump,
    input logic       env_call,
    input logic       brk,
    input logic       fence,
    input logic       illegal,
    input logic       imm_lsb
);

    always_comb begin
        assert_illegal_quiet_R12: assert (!illegal || !(reg_we || mem_rd || mem_wr || branch || jump))
            else $error("illegal word drives an enable");
        assert_no_writeback_R12: assert (!(mem_wr || branch || fence || env_call || brk) || !reg_we)
            else $error("write enable on a non-writing class");
        assert_flags_exclusive_R13: assert ($onehot0({env_call, brk, fence, illegal}))
            else $error("more than one special flag");
        assert_branch_even_R3: assert (!branch || !imm_lsb)
            else $error("odd branch offset");
        assert_load_wb_R7: assert (!mem_rd || (reg_we && wb_sel == 2'd1))
            else $error("load without memory write-back");
        assert_jump_link_R9: assert (!jump || (reg_we && wb_sel == 2'd2))
            else $error("jump without link write-back");
    end

endmodule

bind int_inst_decoder int_inst_decoder_chk u_chk (
    .reg_we   (reg_we_o),
    .wb_sel   (wb_sel_o),
    .mem_rd   (mem_rd_o),
    .mem_wr   (mem_wr_o),
    .branch   (branch_o),
    .jump     (jump_o),
    .env_call (env_call_o),
    .brk      (brk_o),
    .fence    (fence_o),
    .illegal  (illegal_o),
    .imm_lsb  (imm_o[0])
);

// File: tb/int_inst_decoder_tb.sv
`timescale 1ns/1ps
module int_inst_decoder_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] inst = 32'h0;
    logic [4:0]  rd, rs1, rs2;
    logic [31:0] imm;
    logic [3:0]  alu_op;
    logic        a_pc, b_imm, we, mrd, mwr, muns, br, binv, jmp, ec, eb, fn, ill;
    logic [1:0]  wb, msz;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int_inst_decoder u_dut (
        .inst_i(inst), .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2), .imm_o(imm),
        .alu_op_o(alu_op), .src_a_pc_o(a_pc), .src_b_imm_o(b_imm), .reg_we_o(we),
        .wb_sel_o(wb), .mem_rd_o(mrd), .mem_wr_o(mwr), .mem_size_o(msz),
        .mem_unsigned_o(muns), .branch_o(br), .br_inv_o(binv), .jump_o(jmp),
        .env_call_o(ec), .brk_o(eb), .fence_o(fn), .illegal_o(ill)
    );

    typedef struct packed {
        logic [31:0] imm;
        logic [3:0]  alu;
        logic        a_pc, b_imm, we;
        logic [1:0]  wb;
        logic        mrd, mwr;
        logic [1:0]  msz;
        logic        muns, br, binv, jmp, ec, eb, fn, ill;
    } exp_t;

    // reference decode written from the requirement text
    function automatic exp_t model(input logic [31:0] w);
        exp_t e;
        logic [6:0] op = w[6:0];
        logic [2:0] f3 = w[14:12];
        logic [6:0] f7 = w[31:25];
        logic [31:0] ii = {{20{w[31]}}, w[31:20]};
        logic [31:0] si = {{20{w[31]}}, w[31:25], w[11:7]};
        logic [31:0] bi = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
        logic [31:0] ui = {w[31:12], 12'b0};
        logic [31:0] ji = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
        logic [3:0] fcode [8];
        fcode[0] = 4'd0; fcode[1] = 4'd2; fcode[2] = 4'd3; fcode[3] = 4'd4;
        fcode[4] = 4'd5; fcode[5] = 4'd6; fcode[6] = 4'd8; fcode[7] = 4'd9;
        e = '0;
        e.ill = 1'b1;
        case (op)
            7'b0010011: if ((f3 != 1 && f3 != 5) || f7 == 0 || (f3 == 5 && f7 == 7'h20)) begin
                e.ill = 0; e.we = 1; e.b_imm = 1;
                e.imm = (f3 == 1 || f3 == 5) ? {27'b0, w[24:20]} : ii;
                e.alu = (f3 == 5 && f7 == 7'h20) ? 4'd7 : fcode[f3];
            end
            7'b0110011: if (f7 == 0 || (f7 == 7'h20 && (f3 == 0 || f3 == 5))) begin
                e.ill = 0; e.we = 1;
                e.alu = (f7 == 7'h20) ? (f3 == 0 ? 4'd1 : 4'd7) : fcode[f3];
            end
            7'b0110111: begin e.ill = 0; e.we = 1; e.b_imm = 1; e.imm = ui; e.alu = 4'd10; end
            7'b0010111: begin e.ill = 0; e.we = 1; e.b_imm = 1; e.a_pc = 1; e.imm = ui; end
            7'b1101111: begin
                e.ill = 0; e.we = 1; e.b_imm = 1; e.a_pc = 1; e.jmp = 1; e.wb = 2; e.imm = ji;
            end
            7'b1100111: if (f3 == 0) begin
                e.ill = 0; e.we = 1; e.b_imm = 1; e.jmp = 1; e.wb = 2; e.imm = ii;
            end
            7'b1100011: if (f3 != 2 && f3 != 3) begin
                e.ill = 0; e.br = 1; e.binv = f3[0]; e.imm = bi;
                e.alu = (f3 < 2) ? 4'd1 : (f3 < 6 ? 4'd3 : 4'd4);
            end
            7'b0000011: if (f3 == 0 || f3 == 1 || f3 == 2 || f3 == 4 || f3 == 5) begin
                e.ill = 0; e.we = 1; e.b_imm = 1; e.mrd = 1; e.wb = 1;
                e.msz = f3[1:0]; e.muns = f3[2]; e.imm = ii;
            end
            7'b0100011: if (f3 <= 2) begin
                e.ill = 0; e.mwr = 1; e.b_imm = 1; e.msz = f3[1:0]; e.imm = si;
            end
            7'b0001111: if (f3 == 0) begin e.ill = 0; e.fn = 1; end
            7'b1110011: begin
                if (w[31:7] == 25'd0)                          begin e.ill = 0; e.ec = 1; end
                else if (w[31:20] == 12'd1 && w[19:7] == 13'd0) begin e.ill = 0; e.eb = 1; end
            end
            default: ;
        endcase
        return e;
    endfunction

    function automatic string class_tag(input logic [31:0] w);
        case (w[6:0])
            7'b0010011: return (w[13:12] == 2'b01) ? "R4" : "R6";
            7'b0110011: return "R5";
            7'b1100011: return "R8";
            7'b1100111, 7'b1101111: return "R9";
            7'b0000011, 7'b0100011: return "R7";
            7'b1110011: return "R10";
            7'b0001111: return "R11";
            default:    return "R12";
        endcase
    endfunction

    task automatic chk(input string req, input string fld, input logic [31:0] w,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s inst=%h actual=%h expected=%h", req, fld, w, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        exp_t e;
        string ct;
        @(posedge clk);
        #1 inst = w;
        @(negedge clk);
        e  = model(w);
        ct = class_tag(w);
        chk("R2", "rd",  w, {27'b0, rd},  {27'b0, w[11:7]});
        chk("R2", "rs1", w, {27'b0, rs1}, {27'b0, w[19:15]});
        chk("R2", "rs2", w, {27'b0, rs2}, {27'b0, w[24:20]});
        chk((ct == "R4") ? "R4" : "R3", "imm", w, imm, e.imm);
        chk("R6", "alu_op", w, {28'b0, alu_op}, {28'b0, e.alu});
        chk("R1", "src_a_pc", w, {31'b0, a_pc}, {31'b0, e.a_pc});
        chk("R1", "src_b_imm", w, {31'b0, b_imm}, {31'b0, e.b_imm});
        chk("R1", "wb_sel", w, {30'b0, wb}, {30'b0, e.wb});
        chk("R12", "reg_we", w, {31'b0, we}, {31'b0, e.we});
        chk("R7", "mem", w, {27'b0, mrd, mwr, msz, muns}, {27'b0, e.mrd, e.mwr, e.msz, e.muns});
        chk("R8", "branch", w, {30'b0, br, binv}, {30'b0, e.br, e.binv});
        chk("R9", "jump", w, {31'b0, jmp}, {31'b0, e.jmp});
        chk("R10", "sys", w, {30'b0, ec, eb}, {30'b0, e.ec, e.eb});
        chk("R11", "fence", w, {31'b0, fn}, {31'b0, e.fn});
        chk(ct, "illegal", w, {31'b0, ill}, {31'b0, e.ill});
        chk("R13", "flag_count", w, {31'b0, ($countones({ec, eb, fn, ill}) <= 1)}, 32'd1);
    endtask

    initial begin
        logic [6:0] f7s [5];
        f7s[0] = 7'h00; f7s[1] = 7'h20; f7s[2] = 7'h01; f7s[3] = 7'h7F; f7s[4] = 7'h40;

        // power-up word 0 is not a valid encoding: R12
        @(negedge clk);
        chk("R12", "reset_illegal", inst, {31'b0, ill}, 32'd1);
        chk("R12", "reset_we", inst, {31'b0, we}, 32'd0);

        // sweep: every opcode x funct3 x funct7 pattern
        for (int op = 0; op < 128; op++) begin
            for (int f3 = 0; f3 < 8; f3++) begin
                for (int k = 0; k < 5; k++) begin
                    logic [4:0] a = 5'((op * 7 + f3 * 3 + k) % 32);
                    logic [4:0] b = 5'((op * 11 + f3 * 5 + k * 13 + 1) % 32);
                    logic [4:0] c = 5'((op * 3 + f3 * 17 + k * 9 + 2) % 32);
                    apply({f7s[k], c, b, 3'(f3), a, 7'(op)});
                end
            end
        end

        // system words and near misses: R10
        apply(32'h0000_0073);
        apply(32'h0010_0073);
        apply(32'h0020_0073);
        apply(32'h0000_0873);
        apply(32'h0000_8073);
        apply(32'h0010_1073);
        apply(32'h8000_0073);
        // immediate sign extremes: R3
        apply(32'hFFFF_F0EF);
        apply(32'h8000_0063);
        apply(32'h7FF0_0F93);
        apply(32'hFE00_0FA3);
        apply(32'h8000_0037);
        apply(32'hFFFF_F067);
        // shift-immediate corners: R4
        apply(32'h41F0_D093);
        apply(32'h41F0_9093);
        apply(32'h0200_D093);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule